// File: doc/BRIEF.md
# Multiprocessor-Mode Asynchronous Serial Transmitter

This block serializes bytes for an asynchronous line that several receivers share. Each frame carries one extra flag bit after the data. The host sets this bit per byte to mark the frame as an address frame (1) or a data frame (0). The host loads a holding register and hands the byte over by clearing an "empty" flag. A DMA-style master can instead answer the interrupt request with a single write, which stores the byte and clears the flag in one step. All bit timing comes from an external one-cycle `bit_tick` enable. The block does not generate the baud rate.

When the transmitter is switched on, it first sends one whole frame time of 1s. Only after that can a queued byte go out. Bytes that are handed over while a frame is shifting follow it with no gap. A "done" flag reports when the line has drained. When the transmitter is switched off, the pin returns to general-purpose port control. Driving the port as an output with data 0 then holds a break on the line.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset, `empty_flag`=1, `done_flag`=1 and `txi_req`=1.
- R2: While `tx_en`=0, `txd` equals `port_dat` when `port_dir`=1, and is 1 when `port_dir`=0. `port_dir`=1 with `port_dat`=0 gives a break (low line).
- R3: After `tx_en` rises, `txd` stays 1 for 11 bit periods, counted in `bit_tick` pulses. A pending byte's start bit begins at the 11th pulse.
- R4: A frame has 11 bits: bit 0 is the start bit (0), bits 1..8 are the data with the LSB first, bit 9 is the multiprocessor bit, and bit 10 is the stop bit (1). Each bit lasts from one `bit_tick` pulse to the next.
- R5: `host_wr` stores `tx_byte`/`tx_mpb` only while `empty_flag`=1. A write while the flag is 0 leaves the held byte unchanged.
- R6: `host_clr` while `empty_flag`=1 clears both `empty_flag` and `done_flag` in the next cycle. While the flag is 0, `host_clr` has no effect.
- R7: `dma_wr` while `empty_flag`=1 stores the byte and clears `empty_flag` and `done_flag` in one cycle. While the flag is 0, `dma_wr` is ignored.
- R8: While enabled and idle, a pending byte starts at the next `bit_tick`. When a byte moves into the shifter, `empty_flag` returns to 1 in the same cycle that the start bit appears.
- R9: At the pulse that ends a stop bit, a pending byte starts its start bit at once, with no idle bit between frames. If no byte is pending, the line goes idle and `done_flag` is set.
- R10: `txi_req` is 1 exactly while `empty_flag` is 1.
- R11: While `tx_en`=1 and no frame or preamble is shifting, `txd` is 1.
- R12: Clearing `tx_en` in the middle of a frame aborts the frame and returns the pin to port control in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmitter enable |
| host_wr | input | 1 | Host write strobe for the holding register |
| host_clr | input | 1 | Host clear of the empty flag (hands byte over) |
| dma_wr | input | 1 | DMA write: store byte and clear empty flag |
| tx_byte | input | DATA_W | Byte to send |
| tx_mpb | input | 1 | Multiprocessor bit for this byte |
| port_dir | input | 1 | General-purpose port direction (1 = output) |
| port_dat | input | 1 | General-purpose port data |
| txd | output | 1 | Serial line |
| empty_flag | output | 1 | Holding register may be written |
| done_flag | output | 1 | All bytes sent, none pending |
| txi_req | output | 1 | Transmit-data-empty interrupt request |

## Verification
On every cycle, the assertions check the flag handshake. A valid clear or DMA write drops both flags. Writes while full leave the held byte untouched. A load sets the empty flag again and puts a start bit on the line. The line is high whenever the block is enabled and idle. Disabling always ends shifting. The bench scenarios alone show the bit order and the multiprocessor bit of whole frames, the 11-period preamble after enable, the gapless chaining of two frames, and the break produced through the port path.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  typedef enum logic {SH_IDLE, SH_BUSY} sh_state_e;
  localparam int unsigned FRAME_EXTRA = 3; // start, mp bit, stop
endpackage

// File: rtl/mp_uart_hold.sv
module mp_uart_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_clr,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_mpb,
  input  logic              load,
  input  logic              frame_done,
  output logic [DATA_W-1:0] hold_byte,
  output logic              hold_mpb,
  output logic              empty_q,
  output logic              done_q
);
  logic [DATA_W-1:0] byte_n;
  logic              mpb_n, empty_n, done_n;

  always_comb begin
    byte_n  = hold_byte;
    mpb_n   = hold_mpb;
    empty_n = empty_q;
    done_n  = done_q;
    if (frame_done && empty_q) done_n = 1'b1;
    if (empty_q && (host_wr || dma_wr)) begin
      byte_n = tx_byte;
      mpb_n  = tx_mpb;
    end
    if (empty_q && (host_clr || dma_wr)) begin
      empty_n = 1'b0;
      done_n  = 1'b0;
    end
    if (load) empty_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_byte <= '0;
      hold_mpb  <= 1'b0;
      empty_q   <= 1'b1;
      done_q    <= 1'b1;
    end else begin
      hold_byte <= byte_n;
      hold_mpb  <= mpb_n;
      empty_q   <= empty_n;
      done_q    <= done_n;
    end
  end
endmodule

// File: rtl/mp_uart_shift.sv
module mp_uart_shift
  import mp_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              pending,
  input  logic [DATA_W-1:0] hold_byte,
  input  logic              hold_mpb,
  output logic              load,
  output logic              frame_done,
  output logic              busy,
  output logic              line
);
  localparam int unsigned FRAME_BITS = DATA_W + FRAME_EXTRA;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(FRAME_BITS - 1);

  sh_state_e             state_q, state_n;
  logic [IDX_W-1:0]      idx_q, idx_n;
  logic [FRAME_BITS-1:0] frame_q, frame_n;
  logic                  is_data_q, is_data_n;
  logic                  en_q;
  logic                  en_rise;

  assign en_rise = tx_en && !en_q;

  always_comb begin
    state_n    = state_q;
    idx_n      = idx_q;
    frame_n    = frame_q;
    is_data_n  = is_data_q;
    load       = 1'b0;
    frame_done = 1'b0;
    if (!tx_en) begin
      state_n = SH_IDLE;
    end else if (en_rise) begin
      state_n   = SH_BUSY;
      idx_n     = '0;
      frame_n   = '1;
      is_data_n = 1'b0;
    end else if (bit_tick) begin
      if (state_q == SH_BUSY && idx_q != LAST) begin
        idx_n = idx_q + 1'b1;
      end else begin
        frame_done = (state_q == SH_BUSY) && is_data_q;
        if (pending) begin
          load      = 1'b1;
          state_n   = SH_BUSY;
          idx_n     = '0;
          frame_n   = {1'b1, hold_mpb, hold_byte, 1'b0};
          is_data_n = 1'b1;
        end else begin
          state_n = SH_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SH_IDLE;
      idx_q     <= '0;
      frame_q   <= '1;
      is_data_q <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      state_q   <= state_n;
      idx_q     <= idx_n;
      frame_q   <= frame_n;
      is_data_q <= is_data_n;
      en_q      <= tx_en;
    end
  end

  assign busy = (state_q == SH_BUSY);
  assign line = busy ? frame_q[idx_q] : 1'b1;
endmodule

// File: rtl/mp_uart_pinmux.sv
module mp_uart_pinmux (
  input  logic tx_en,
  input  logic line,
  input  logic port_dir,
  input  logic port_dat,
  output logic pin
);
  always_comb begin
    if (tx_en)         pin = line;
    else if (port_dir) pin = port_dat;
    else               pin = 1'b1;
  end
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              host_wr,
  input  logic              host_clr,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_mpb,
  input  logic              port_dir,
  input  logic              port_dat,
  output logic              txd,
  output logic              empty_flag,
  output logic              done_flag,
  output logic              txi_req
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [DATA_W-1:0] hold_byte;
  logic              hold_mpb, load, frame_done, busy, line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mp_uart_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .host_wr(host_wr), .host_clr(host_clr),
    .dma_wr(dma_wr), .tx_byte(tx_byte), .tx_mpb(tx_mpb), .load(load),
    .frame_done(frame_done), .hold_byte(hold_byte), .hold_mpb(hold_mpb),
    .empty_q(empty_flag), .done_q(done_flag)
  );

  mp_uart_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .pending(!empty_flag), .hold_byte(hold_byte), .hold_mpb(hold_mpb),
    .load(load), .frame_done(frame_done), .busy(busy), .line(line)
  );

  mp_uart_pinmux u_pin (
    .tx_en(tx_en), .line(line), .port_dir(port_dir), .port_dat(port_dat),
    .pin(txd)
  );

  assign txi_req = empty_flag;
endmodule

// File: rtl/mp_uart_tx_chk.sv
module mp_uart_tx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              tx_en,
  input logic              host_clr,
  input logic              dma_wr,
  input logic              txd,
  input logic              empty_flag,
  input logic              done_flag,
  input logic [DATA_W-1:0] hold_byte,
  input logic              load,
  input logic              frame_done,
  input logic              busy
);
  p_clear_drops_flags_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (empty_flag && host_clr) |=> (!empty_flag && !done_flag));

  p_dma_drops_flags_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (empty_flag && dma_wr) |=> (!empty_flag && !done_flag));

  p_full_holds_byte_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!empty_flag && !load) |=> $stable(hold_byte));

  p_load_refills_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    load |=> (empty_flag && (!tx_en || txd == 1'b0)));

  p_end_sets_done_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_done && empty_flag && !host_clr && !dma_wr) |=> done_flag);

  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_en && !busy) |-> txd);

  p_disable_stops_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tx_en |=> !busy);
endmodule

bind mp_uart_tx mp_uart_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .tx_en(tx_en), .host_clr(host_clr),
  .dma_wr(dma_wr), .txd(txd), .empty_flag(empty_flag), .done_flag(done_flag),
  .hold_byte(hold_byte), .load(load), .frame_done(frame_done), .busy(busy)
);

// File: tb/tb_mp_uart_tx.sv
module tb_mp_uart_tx;
  localparam int unsigned DW = 8;
  localparam logic [8:0] VEC [6] = '{9'h1_A5, 9'h0_3C, 9'h1_00, 9'h0_FF, 9'h1_81, 9'h0_6E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, tx_en = 1'b0, host_wr = 1'b0, host_clr = 1'b0, dma_wr = 1'b0;
  logic [DW-1:0] tx_byte = '0;
  logic tx_mpb = 1'b0, port_dir = 1'b0, port_dat = 1'b0;
  logic txd, empty_flag, done_flag, txi_req;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mp_uart_tx #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .host_wr(host_wr), .host_clr(host_clr), .dma_wr(dma_wr),
    .tx_byte(tx_byte), .tx_mpb(tx_mpb), .port_dir(port_dir),
    .port_dat(port_dat), .txd(txd), .empty_flag(empty_flag),
    .done_flag(done_flag), .txi_req(txi_req)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    bit_tick = 1'b1; cyc(); bit_tick = 1'b0; cyc(); cyc();
  endtask

  task automatic host_send(input logic [7:0] b, input logic m);
    tx_byte = b; tx_mpb = m; host_wr = 1'b1; cyc(); host_wr = 1'b0;
    host_clr = 1'b1; cyc(); host_clr = 1'b0;
  endtask

  // ticks through one frame from the start bit; start bit appears at first tick
  task automatic frame_check(input logic [7:0] b, input logic m, input string req);
    logic [10:0] exp;
    exp = {1'b1, m, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      tick();
      check(req, txd, exp[i]);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    // R1 reset state
    check("R1 empty", empty_flag, 1);
    check("R1 done", done_flag, 1);
    check("R1 txi", txi_req, 1);
    check("R10 txi follows empty", txi_req, empty_flag);
    // R2 port control and break
    check("R2 undriven high", txd, 1);
    port_dir = 1'b1; port_dat = 1'b0; cyc();
    check("R2 break", txd, 0);
    port_dat = 1'b1; cyc();
    check("R2 port data", txd, 1);
    port_dir = 1'b0;

    // R3 preamble with a byte already pending
    host_send(8'h5A, 1'b1);
    check("R6 empty cleared", empty_flag, 0);
    check("R6 done cleared", done_flag, 0);
    check("R10 txi low", txi_req, 0);
    tx_en = 1'b1; cyc();
    for (int i = 0; i < 10; i++) begin
      tick();
      check("R3 preamble high", txd, 1);
    end
    tick();
    check("R3 start after preamble", txd, 0);
    check("R8 empty refilled", empty_flag, 1);
    for (int i = 1; i < 11; i++) begin
      tick();
      check("R4 bit", txd, (i <= 8) ? 32'((8'h5A >> (i - 1)) & 1) : (i == 9 ? 1 : 1));
    end
    tick();
    check("R9 done set", done_flag, 1);
    check("R11 idle high", txd, 1);

    // table walk: each vector sent by the host, frame compared bit by bit
    for (int v = 0; v < 6; v++) begin
      host_send(VEC[v][7:0], VEC[v][8]);
      check("R11 idle while pending", txd, 1);
      frame_check(VEC[v][7:0], VEC[v][8], "R4 frame");
      tick();
      check("R9 done after frame", done_flag, 1);
    end

    // R5/R6/R7 ignored operations while full
    host_send(8'hC3, 1'b0);
    tx_byte = 8'h11; tx_mpb = 1'b1; host_wr = 1'b1; cyc(); host_wr = 1'b0;
    host_clr = 1'b1; cyc(); host_clr = 1'b0;
    check("R6 clear while full no effect", empty_flag, 0);
    check("R6 done stays low", done_flag, 0);
    dma_wr = 1'b1; tx_byte = 8'h22; cyc(); dma_wr = 1'b0;
    check("R7 dma while full ignored", empty_flag, 0);
    frame_check(8'hC3, 1'b0, "R5 byte kept");
    tick();

    // R7 DMA write, and R9 gapless chaining
    tx_byte = 8'h96; tx_mpb = 1'b1; dma_wr = 1'b1; cyc(); dma_wr = 1'b0;
    check("R7 dma clears empty", empty_flag, 0);
    check("R7 dma clears done", done_flag, 0);
    tick();
    check("R8 start", txd, 0);
    check("R8 empty", empty_flag, 1);
    host_send(8'h3B, 1'b0);
    for (int i = 1; i < 11; i++) tick();
    check("R9 stop bit", txd, 1);
    tick();
    check("R9 next start no gap", txd, 0);
    check("R9 done stays low", done_flag, 0);
    for (int i = 1; i < 11; i++) begin
      tick();
      check("R9 chained bit", txd, (i <= 8) ? 32'((8'h3B >> (i - 1)) & 1) : (i == 9 ? 0 : 1));
    end
    tick();
    check("R9 done after chain", done_flag, 1);

    // R12 abort mid-frame then break
    host_send(8'h00, 1'b0);
    tick(); tick();
    check("R12 data low mid frame", txd, 0);
    port_dir = 1'b1; port_dat = 1'b1; tx_en = 1'b0; cyc();
    check("R12 port takes pin", txd, 1);
    port_dat = 1'b0; cyc();
    check("R12 break after abort", txd, 0);
    tx_en = 1'b1; cyc();
    tick();
    check("R3 preamble after re-enable", txd, 1);

    finished = 1'b1;
    summary();
  end
endmodule